// File: doc/BRIEF.md
# Background Copy Engine with Read Redirection

The block copies a contiguous run of words from a slow, flash-like memory into a fast local SRAM while the CPU keeps fetching. Software sets a source word address, a word count and a destination word address, then writes a start bit. From then on the engine copies one word at a time in the background.

Each CPU read is checked against the copy's progress. When the requested word lies inside the source window and has already been written to SRAM, the read is served from SRAM at the matching destination offset. Any other read goes straight to the slow memory. Execution therefore never waits for the transfer, and correctness never depends on the transfer finishing. A CPU access always wins a port over the copy, and the copy stalls until the port is free.

Top module: `copy_redirect_engine`

## Requirements
- R1: After reset `busy_o` is 0, neither memory port is requested and no response is pending. With no copy programmed, a CPU read goes to the slow memory.
- R2: Register map on `reg_sel_i`: 0 is the source address, 1 the word count, 2 the destination address and 3 the control register, where bit 0 written as 1 means start. A start with a nonzero count raises `busy_o` on the next cycle. Word `src+i` is then written to SRAM address `dst+i`, in increasing order of i. `busy_o` falls in the cycle after the last SRAM write.
- R3: A CPU read whose offset `addr-src` is below the number of words already written is served from SRAM at address `dst+offset`, in the cycle of the request and with write enable low.
- R4: A CPU read outside the window, or to a word not yet written, drives the slow port with the CPU's own address in the cycle of the request.
- R5: Every request raises `cpu_rvalid_o` exactly one cycle later, with data equal to the memory content at the requested address, whichever path served it.
- R6: When a CPU read needs the slow port, the copy issues no read of its own. A copy held off for many cycles still completes with all words correct.
- R7: When a CPU read is served from SRAM, the copy does not write SRAM in that cycle. A copy that keeps losing SRAM cycles to the CPU still completes correctly.
- R8: Register writes, including a start, are ignored while `busy_o` is 1. The running copy keeps its window and its word count.
- R9: A start with a count of zero leaves `busy_o` at 0 and causes no traffic on either port. Afterwards every read goes to the slow memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | AW | Register write data |
| busy_o | output | 1 | Copy in progress |
| cpu_req_i | input | 1 | CPU read request |
| cpu_addr_i | input | AW | CPU word address |
| cpu_rvalid_o | output | 1 | CPU read data valid |
| cpu_rdata_o | output | DW | CPU read data |
| slow_req_o | output | 1 | Slow memory read request |
| slow_addr_o | output | AW | Slow memory word address |
| slow_rdata_i | input | DW | Slow memory data, one cycle after request |
| sram_en_o | output | 1 | SRAM access enable |
| sram_we_o | output | 1 | SRAM write enable |
| sram_addr_o | output | AW | SRAM word address |
| sram_wdata_o | output | DW | SRAM write data |
| sram_rdata_i | input | DW | SRAM read data, one cycle after read |

## Verification
Routing appears on the ports in the cycle of the request. Inputs are driven on the falling edge, and the port request lines are sampled shortly after that edge, before the next rising edge. Read data and `cpu_rvalid_o` are due one rising edge later and are checked at the following falling edge. `busy_o` is checked on the falling edge after the rising edge that wrote the last word. The expected route of each CPU read is computed from the count of SRAM writes seen at the ports, so reads issued in the middle of a copy are predicted without looking at the engine's pointer.

// File: rtl/cre_pkg.sv
package cre_pkg;
  typedef enum logic [1:0] {
    SEL_SRC  = 2'd0,
    SEL_SIZE = 2'd1,
    SEL_DST  = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cre_regs.sv
module cre_regs
  import cre_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    sel_i,
  input  logic [AW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] size_o,
  output logic [AW-1:0] dst_o,
  output logic          start_o
);
  logic wr_ok;
  assign wr_ok   = we_i && !busy_i;
  assign start_o = wr_ok && (reg_sel_e'(sel_i) == SEL_CTRL) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o  <= '0;
      size_o <= '0;
      dst_o  <= '0;
    end else if (wr_ok) begin
      case (reg_sel_e'(sel_i))
        SEL_SRC:  src_o  <= wdata_i;
        SEL_SIZE: size_o <= wdata_i;
        SEL_DST:  dst_o  <= wdata_i;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/cre_copier.sv
module cre_copier #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] size_i,
  input  logic          cpu_slow_i,
  input  logic          cpu_sram_i,
  input  logic [DW-1:0] slow_rdata_i,
  output logic          busy_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic          issue_o,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o
);
  logic          inflight_q;
  logic          hold_v_q;
  logic [DW-1:0] hold_q;

  // one word in flight or parked at a time
  assign issue_o   = busy_o && (rd_ptr_o != size_i) && !inflight_q && !hold_v_q && !cpu_slow_i;
  assign wr_en_o   = (inflight_q || hold_v_q) && !cpu_sram_i;
  assign wr_data_o = hold_v_q ? hold_q : slow_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o     <= 1'b0;
      rd_ptr_o   <= '0;
      wr_ptr_o   <= '0;
      inflight_q <= 1'b0;
      hold_v_q   <= 1'b0;
      hold_q     <= '0;
    end else if (start_i) begin
      busy_o     <= (size_i != '0);
      rd_ptr_o   <= '0;
      wr_ptr_o   <= '0;
      inflight_q <= 1'b0;
      hold_v_q   <= 1'b0;
    end else begin
      inflight_q <= issue_o;
      if (issue_o) rd_ptr_o <= rd_ptr_o + 1'b1;
      if (wr_en_o) begin
        wr_ptr_o <= wr_ptr_o + 1'b1;
        hold_v_q <= 1'b0;
        if (wr_ptr_o + 1'b1 == size_i) busy_o <= 1'b0;
      end else if (inflight_q) begin
        hold_v_q <= 1'b1;
        hold_q   <= slow_rdata_i;
      end
    end
  end
endmodule

// File: rtl/cre_redirect.sv
module cre_redirect #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_req_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] rd_ptr_i,
  input  logic [AW-1:0] wr_ptr_i,
  input  logic          issue_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] slow_rdata_i,
  input  logic [DW-1:0] sram_rdata_i,
  output logic          cpu_slow_o,
  output logic          cpu_sram_o,
  output logic          slow_req_o,
  output logic [AW-1:0] slow_addr_o,
  output logic          sram_en_o,
  output logic          sram_we_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o
);
  logic [AW-1:0] off;
  logic          hit;
  logic          hit_q;

  assign off        = cpu_addr_i - src_i;
  assign hit        = off < wr_ptr_i;  // wraps for addresses below src
  assign cpu_sram_o = cpu_req_i && hit;
  assign cpu_slow_o = cpu_req_i && !hit;

  assign slow_req_o   = cpu_slow_o || issue_i;
  assign slow_addr_o  = cpu_slow_o ? cpu_addr_i : src_i + rd_ptr_i;
  assign sram_en_o    = cpu_sram_o || wr_en_i;
  assign sram_we_o    = !cpu_sram_o && wr_en_i;
  assign sram_addr_o  = cpu_sram_o ? dst_i + off : dst_i + wr_ptr_i;
  assign sram_wdata_o = wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rvalid_o <= 1'b0;
      hit_q        <= 1'b0;
    end else begin
      cpu_rvalid_o <= cpu_req_i;
      hit_q        <= hit;
    end
  end

  assign cpu_rdata_o = hit_q ? sram_rdata_i : slow_rdata_i;
endmodule

// File: rtl/copy_redirect_engine.sv
module copy_redirect_engine #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          busy_o,
  input  logic          cpu_req_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          cpu_rvalid_o,
  output logic [DW-1:0] cpu_rdata_o,
  output logic          slow_req_o,
  output logic [AW-1:0] slow_addr_o,
  input  logic [DW-1:0] slow_rdata_i,
  output logic          sram_en_o,
  output logic          sram_we_o,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_wdata_o,
  input  logic [DW-1:0] sram_rdata_i
);
  logic [AW-1:0] src, size, dst, rd_ptr, wr_ptr;
  logic          start, issue, wr_en, cpu_slow, cpu_sram;
  logic [DW-1:0] wr_data;

  cre_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i), .busy_i(busy_o),
    .src_o(src), .size_o(size), .dst_o(dst), .start_o(start)
  );

  cre_copier #(.AW(AW), .DW(DW)) u_copier (
    .clk_i, .rst_ni,
    .start_i(start), .size_i(size), .cpu_slow_i(cpu_slow), .cpu_sram_i(cpu_sram),
    .slow_rdata_i, .busy_o, .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr),
    .issue_o(issue), .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  cre_redirect #(.AW(AW), .DW(DW)) u_redirect (
    .clk_i, .rst_ni,
    .cpu_req_i, .cpu_addr_i, .src_i(src), .dst_i(dst),
    .rd_ptr_i(rd_ptr), .wr_ptr_i(wr_ptr), .issue_i(issue),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .slow_rdata_i, .sram_rdata_i,
    .cpu_slow_o(cpu_slow), .cpu_sram_o(cpu_sram),
    .slow_req_o, .slow_addr_o, .sram_en_o, .sram_we_o, .sram_addr_o, .sram_wdata_o,
    .cpu_rvalid_o, .cpu_rdata_o
  );
endmodule

// File: rtl/cre_checker.sv
module cre_checker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          cpu_req_i,
  input logic [AW-1:0] cpu_addr_i,
  input logic          cpu_rvalid_o,
  input logic          slow_req_o,
  input logic [AW-1:0] slow_addr_o,
  input logic          sram_en_o,
  input logic          sram_we_o
);
  AST_IDLE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(sram_en_o && sram_we_o)); // R2
  AST_BUSY_END_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(sram_en_o && sram_we_o)); // R2
  AST_RESP_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |=> cpu_rvalid_o); // R5
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_req_i |=> !cpu_rvalid_o); // R5
  AST_CPU_ROUTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && !(sram_en_o && !sram_we_o) |-> slow_req_o && slow_addr_o == cpu_addr_i); // R6
  AST_SRAM_CPU_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && sram_en_o && sram_we_o |-> slow_req_o && slow_addr_o == cpu_addr_i); // R7
endmodule

bind copy_redirect_engine cre_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o),
  .cpu_req_i(cpu_req_i), .cpu_addr_i(cpu_addr_i), .cpu_rvalid_o(cpu_rvalid_o),
  .slow_req_o(slow_req_o), .slow_addr_o(slow_addr_o),
  .sram_en_o(sram_en_o), .sram_we_o(sram_we_o)
);

// File: tb/copy_redirect_engine_test.sv
`timescale 1ns/1ps
module copy_redirect_engine_test;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0, cpu_req = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [AW-1:0] reg_wdata = '0, cpu_addr = '0;
  logic busy_o, cpu_rvalid_o, slow_req_o, sram_en_o, sram_we_o;
  logic [DW-1:0] cpu_rdata_o, sram_wdata_o;
  logic [DW-1:0] slow_rdata = '0, sram_rdata = '0;
  logic [AW-1:0] slow_addr_o, sram_addr_o;
  logic [DW-1:0] sram [256];
  int n_chk = 0, n_fail = 0, wr_cnt = 0;
  logic [AW-1:0] cur_src = '0, cur_dst = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  copy_redirect_engine #(.AW(AW), .DW(DW)) uut (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .busy_o, .cpu_req_i(cpu_req), .cpu_addr_i(cpu_addr), .cpu_rvalid_o, .cpu_rdata_o,
    .slow_req_o, .slow_addr_o, .slow_rdata_i(slow_rdata),
    .sram_en_o, .sram_we_o, .sram_addr_o, .sram_wdata_o, .sram_rdata_i(sram_rdata)
  );

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {a ^ 16'hA55A, a};
  endfunction

  always @(posedge clk) if (slow_req_o) slow_rdata <= mem_val(slow_addr_o);
  always @(posedge clk) if (sram_en_o) begin
    if (sram_we_o) begin
      sram[sram_addr_o[7:0]] <= sram_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end else sram_rdata <= sram[sram_addr_o[7:0]];
  end

  task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [AW-1:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // src, size, dst, start
  task automatic launch(logic [AW-1:0] s, logic [AW-1:0] n, logic [AW-1:0] d);
    wr_reg(2'd0, s); wr_reg(2'd1, n); wr_reg(2'd2, d);
    @(negedge clk); wr_cnt = 0;
    reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 16'h0001;
    @(negedge clk);
    reg_we = 1'b0;
    cur_src = s; cur_dst = d;
  endtask

  task automatic cpu_read(logic [AW-1:0] a, bit exp_hit, string req);
    @(negedge clk);
    cpu_req = 1'b1; cpu_addr = a;
    #0.5;
    if (exp_hit)
      chk(sram_en_o && !sram_we_o && sram_addr_o == cur_dst + (a - cur_src), req,
          {sram_en_o, sram_we_o, 14'd0, sram_addr_o}, {2'b10, 14'd0, cur_dst + (a - cur_src)});
    else
      chk(slow_req_o && slow_addr_o == a, req, {15'd0, slow_req_o, slow_addr_o}, {15'd0, 1'b1, a});
    @(negedge clk);
    cpu_req = 1'b0;
    chk(cpu_rvalid_o && cpu_rdata_o == mem_val(a), "R5 response", cpu_rdata_o, mem_val(a));
  endtask

  task automatic wait_done(int n);
    for (int i = 0; i < 400 && busy_o; i++) @(negedge clk);
    chk(!busy_o && wr_cnt == n, "R2 busy falls after last write", wr_cnt, n);
  endtask

  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'h0100}, {1'b1, 16'h0107}, {1'b0, 16'h0108},
    {1'b0, 16'h00FF}, {1'b0, 16'h0000}, {1'b1, 16'h0103}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #0.5;
    // R1 reset state
    chk(!busy_o && !slow_req_o && !sram_en_o && !cpu_rvalid_o, "R1 reset idle",
        {busy_o, slow_req_o, sram_en_o, cpu_rvalid_o}, 0);
    cpu_read(16'h0000, 1'b0, "R1 read before any copy");

    // R2 basic copy
    launch(16'h0100, 16'd8, 16'h0020);
    chk(busy_o, "R2 busy after start", busy_o, 1);
    wait_done(8);
    for (int i = 0; i < 8; i++)
      chk(sram[8'h20 + i] == mem_val(16'h0100 + i), "R2 copied word",
          sram[8'h20 + i], mem_val(16'h0100 + i));

    // R3/R4/R5 table walk over the finished window
    foreach (VEC[k])
      cpu_read(VEC[k][15:0], VEC[k][16], VEC[k][16] ? "R3 hit to SRAM" : "R4 miss to slow");

    // R9 zero size
    wr_reg(2'd1, 16'd0);
    @(negedge clk); reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 16'h0001;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); reg_we = 1'b0; #0.5;
      chk(!busy_o && !slow_req_o && !sram_en_o, "R9 zero size idle",
          {busy_o, slow_req_o, sram_en_o}, 0);
    end
    cpu_read(16'h0100, 1'b0, "R9 read after zero size");

    // R6 CPU holds slow port, copy must stall
    launch(16'h0200, 16'd16, 16'h0040);
    cpu_req = 1'b1; cpu_addr = 16'h02F0;
    for (int i = 0; i < 8; i++) begin
      #0.5;
      chk(slow_req_o && slow_addr_o == 16'h02F0, "R6 CPU owns slow port", slow_addr_o, 16'h02F0);
      @(negedge clk);
      chk(cpu_rvalid_o && cpu_rdata_o == mem_val(16'h02F0), "R5 streamed response",
          cpu_rdata_o, mem_val(16'h02F0));
    end
    cpu_req = 1'b0;
    chk(wr_cnt == 0 && busy_o, "R6 copy stalled", wr_cnt, 0);
    wait_done(16);
    for (int i = 0; i < 16; i++)
      chk(sram[8'h40 + i] == mem_val(16'h0200 + i), "R6 word after stall",
          sram[8'h40 + i], mem_val(16'h0200 + i));

    // R7/R8 reads during copy, register writes while busy
    launch(16'h0300, 16'd12, 16'h0080);
    wr_reg(2'd0, 16'h0500);
    wr_reg(2'd3, 16'h0001);
    for (int i = 0; i < 30; i++) begin
      logic [AW-1:0] a;
      a = 16'h0300 + AW'(i % 12);
      @(negedge clk);
      cpu_read(a, busy_o ? (int'(a - cur_src) < wr_cnt) : 1'b1, "R7 read during copy");
    end
    wait_done(12);
    chk(wr_cnt == 12, "R8 no restart while busy", wr_cnt, 12);
    for (int i = 0; i < 12; i++)
      chk(sram[8'h80 + i] == mem_val(16'h0300 + i), "R7 word after SRAM contention",
          sram[8'h80 + i], mem_val(16'h0300 + i));
    cpu_read(16'h0305, 1'b1, "R8 window kept");
    cpu_read(16'h0500, 1'b0, "R8 source write ignored");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule